// File: doc/BRIEF.md
# Multi-Context Interrupt Claim and Completion Controller

This block collects interrupt requests from a set of level-signalled sources and hands them out to several target contexts, for example processor harts. Every source carries a programmable priority and a gateway that tracks whether the request is waiting (pending) or being serviced (active). Every context has its own bitmap of enabled sources, its own threshold and its own claim/complete register. A context learns about work through its interrupt output. It reads its claim register to take the best waiting source, and it writes that source's ID back when the handler is done.

Completion is deliberately loose. A completion write is not matched against the ID the context last claimed. It is honoured whenever the writing context has that ID enabled, and it is dropped without any effect otherwise. Software can therefore claim a source through one context and retire it through another, which keeps a source from being stranded when it is moved between contexts mid-service. A source that is claimed but never retired stays active and is not offered again.

All configuration and the claim/complete traffic use a simple single-port register bus. A read returns its data one cycle later, qualified by a valid strobe. Addresses are 32-bit words. Bits [11:10] select a region, and bits [9:0] select a field within it.

Top module: `irq_claim_ctrl`

## Requirements
- R1: A read of context c's claim register (address 0xC01 + 2c) returns the eligible source with the highest priority, and the lowest ID among equal priorities. A source is eligible for c when it is pending, has its bit set in c's enable map, and has a priority strictly greater than c's threshold (address 0xC00 + 2c).
- R2: A claim read returns 0 when no source is eligible for that context. A source with priority 0 is never eligible.
- R3: A claim that returns a nonzero ID clears that source's pending state and sets its active state in the same clock edge. While active, the source is offered to no context, even if its request line stays high.
- R4: A write of ID n to context c's claim/complete register ends source n's active state when c has source n enabled, whichever context made the claim. A source whose request is still high becomes pending again afterwards.
- R5: A completion write is ignored, and the active state is left unchanged, when the writing context has the ID disabled or when the ID is 0 or greater than NUM_SRC.
- R6: Enable maps are packed 32 to a word. Source n sits at word n/32, bit n%32, and context c's word w lives at address 0x800 + 32c + w. Bit 0 of word 0 (ID 0) always reads 0.
- R7: Source n's priority register is at address n (1 to NUM_SRC) and reads back as written. A priority of 1 is a valid nonzero priority. Address 0 reads as 0.
- R8: irq_out[c] is a registered flag. It is high exactly when at least one source was eligible for context c in the previous cycle.
- R9: Pending word w (address 0x400 + w) reads the gateways' pending bits in the same packed layout as the enable maps. Writes to that region have no effect.
- R10: After synchronous reset, all priorities, enables, thresholds, pending and active states are zero, irq_out is low and bus_rvalid is low.
- R11: bus_rvalid is high in the cycle after an accepted read, and only then. bus_rdata holds the read data in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | NUM_SRC | Level request lines; bit n-1 is source n |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| irq_out | output | NUM_CTX | Per-context interrupt request |

## Verification
The bench targets cross-context completion: it retires on context 1 a source claimed on context 0. A design that insisted on a matching claimant would leave that source stuck active and never raise context 1's line again. It writes completions from a context without the ID enabled, and with IDs 0 and out of range. A design that honoured those writes would re-pend the still-asserted source, and the pending word would show it. Priority ties, a priority of 1 in the second enable word, a priority-0 source and a threshold equal to a source's priority are all probed through claim reads. An arbiter with the wrong tie rule, a greater-or-equal threshold compare or a misplaced enable bit returns a different ID. Double presentation of an active source shows up as a repeated ID or a raised interrupt line.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 12;
  localparam int FLD_W  = 10;

  typedef enum logic [1:0] {
    RG_PRIO = 2'd0,
    RG_PEND = 2'd1,
    RG_EN   = 2'd2,
    RG_CTX  = 2'd3
  } region_e;

  function automatic int words_for(input int nsrc);
    return nsrc / 32 + 1;
  endfunction
endpackage

// File: rtl/irq_cfg_store.sv
module irq_cfg_store
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  localparam int NWORDS = words_for(NUM_SRC)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_prio,
  input  logic [FLD_W-1:0]              prio_idx,
  input  logic                          wr_en,
  input  logic [4:0]                    en_ctx,
  input  logic [4:0]                    en_word,
  input  logic                          wr_thr,
  input  logic [FLD_W-2:0]              thr_ctx,
  input  logic [BUS_W-1:0]              wdata,
  output logic [NUM_SRC*PRIO_W-1:0]     prio_flat,
  output logic [NUM_CTX*NWORDS*32-1:0]  en_flat,
  output logic [NUM_CTX*PRIO_W-1:0]     thr_flat
);
  // one priority register per real source (ID 1..NUM_SRC)
  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_prio
    always_ff @(posedge clk) begin
      if (rst)
        prio_flat[(s-1)*PRIO_W +: PRIO_W] <= '0;
      else if (wr_prio && int'(prio_idx) == s)
        prio_flat[(s-1)*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
    end
  end

  // per-context enable words; bit 0 of word 0 is the non-source ID 0
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
      localparam logic [31:0] KEEP = (w == 0) ? 32'hFFFF_FFFE : 32'hFFFF_FFFF;
      always_ff @(posedge clk) begin
        if (rst)
          en_flat[(c*NWORDS + w)*32 +: 32] <= '0;
        else if (wr_en && int'(en_ctx) == c && int'(en_word) == w)
          en_flat[(c*NWORDS + w)*32 +: 32] <= wdata & KEEP;
      end
    end

    always_ff @(posedge clk) begin
      if (rst)
        thr_flat[c*PRIO_W +: PRIO_W] <= '0;
      else if (wr_thr && int'(thr_ctx) == c)
        thr_flat[c*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
    end
  end
endmodule

// File: rtl/irq_src_gate.sv
module irq_src_gate #(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC:1]   req,
  input  logic [NUM_SRC:1]   claim,
  input  logic [NUM_SRC:1]   done,
  output logic [NUM_SRC:1]   pend,
  output logic [NUM_SRC:1]   act
);
  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[s] <= 1'b0;
        act[s]  <= 1'b0;
      end else if (claim[s]) begin
        pend[s] <= 1'b0;
        act[s]  <= 1'b1;
      end else begin
        if (done[s])
          act[s] <= 1'b0;
        if (req[s] && !act[s] && !pend[s])
          pend[s] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_ctx_arb.sv
module irq_ctx_arb #(
  parameter int NUM_SRC = 40,
  parameter int PRIO_W  = 3,
  localparam int IDW    = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC:1]          pend,
  input  logic [NUM_SRC:1]          en,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]         thr,
  output logic [IDW-1:0]            best_id,
  output logic                      any
);
  logic [PRIO_W-1:0] best_p;

  // ascending scan with strict compare: ties keep the lowest ID,
  // and seeding with the threshold enforces prio > thr (hence > 0)
  always_comb begin
    best_p  = thr;
    best_id = '0;
    for (int s = 1; s <= NUM_SRC; s++) begin
      if (pend[s] && en[s] && prio_flat[(s-1)*PRIO_W +: PRIO_W] > best_p) begin
        best_p  = prio_flat[(s-1)*PRIO_W +: PRIO_W];
        best_id = IDW'(s);
      end
    end
    any = (best_id != '0);
  end
endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               bus_rvalid,
  output logic [NUM_CTX-1:0] irq_out
);
  localparam int NWORDS = words_for(NUM_SRC);
  localparam int IDW    = $clog2(NUM_SRC + 1);

  // address decode
  region_e            region;
  logic [FLD_W-1:0]   fld;
  logic [4:0]         e_ctx, e_word;
  logic [FLD_W-2:0]   c_ctx;
  logic               c_sel, ctx_ok, rd_req;

  assign region = region_e'(bus_addr[ADDR_W-1 -: 2]);
  assign fld    = bus_addr[FLD_W-1:0];
  assign e_ctx  = fld[9:5];
  assign e_word = fld[4:0];
  assign c_ctx  = fld[9:1];
  assign c_sel  = fld[0];
  assign ctx_ok = int'(c_ctx) < NUM_CTX;
  assign rd_req = bus_sel && !bus_wr;

  logic wr_prio, wr_en, wr_thr, rd_claim, wr_comp;
  assign wr_prio  = bus_sel && bus_wr && region == RG_PRIO;
  assign wr_en    = bus_sel && bus_wr && region == RG_EN;
  assign wr_thr   = bus_sel && bus_wr && region == RG_CTX && !c_sel;
  assign rd_claim = rd_req && region == RG_CTX && c_sel && ctx_ok;
  assign wr_comp  = bus_sel && bus_wr && region == RG_CTX && c_sel && ctx_ok;

  // configuration
  logic [NUM_SRC*PRIO_W-1:0]    prio_flat;
  logic [NUM_CTX*NWORDS*32-1:0] en_flat;
  logic [NUM_CTX*PRIO_W-1:0]    thr_flat;

  irq_cfg_store #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_prio  (wr_prio),
    .prio_idx (fld),
    .wr_en    (wr_en),
    .en_ctx   (e_ctx),
    .en_word  (e_word),
    .wr_thr   (wr_thr),
    .thr_ctx  (c_ctx),
    .wdata    (bus_wdata),
    .prio_flat(prio_flat),
    .en_flat  (en_flat),
    .thr_flat (thr_flat)
  );

  // gateways
  logic [NUM_SRC:1] pend_q, act_q, claim_vec, comp_vec;

  irq_src_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .clk  (clk),
    .rst  (rst),
    .req  (src_irq),
    .claim(claim_vec),
    .done (comp_vec),
    .pend (pend_q),
    .act  (act_q)
  );

  // per-context arbitration; enable bit n of a context is flat bit n
  logic [NUM_SRC:1]    en_bits [NUM_CTX];
  logic [IDW-1:0]      best_arr[NUM_CTX];
  logic [NUM_CTX-1:0]  any_vec;

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_arb
    assign en_bits[c] = en_flat[c*NWORDS*32 + 1 +: NUM_SRC];
    irq_ctx_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
      .pend     (pend_q),
      .en       (en_bits[c]),
      .prio_flat(prio_flat),
      .thr      (thr_flat[c*PRIO_W +: PRIO_W]),
      .best_id  (best_arr[c]),
      .any      (any_vec[c])
    );
  end

  // claim and completion steering (single bus: at most one per cycle)
  logic [IDW-1:0]   claim_id;
  logic [PRIO_W-1:0] thr_sel;
  logic [NUM_SRC:1] comp_en;

  always_comb begin
    claim_id = '0;
    thr_sel  = '0;
    comp_en  = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (int'(c_ctx) == c) begin
        thr_sel = thr_flat[c*PRIO_W +: PRIO_W];
        comp_en = en_bits[c];
        if (rd_claim)
          claim_id = best_arr[c];
      end
    end
  end

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_steer
    assign claim_vec[s] = (claim_id == IDW'(s));
    assign comp_vec[s]  = wr_comp && comp_en[s] && (bus_wdata == BUS_W'(s));
  end

  // read mux
  logic [NWORDS*32-1:0] pend_words;
  logic [BUS_W-1:0]     rd_next;

  assign pend_words = {{(NWORDS*32-NUM_SRC-1){1'b0}}, pend_q, 1'b0};

  always_comb begin
    rd_next = '0;
    unique case (region)
      RG_PRIO: begin
        if (fld != '0 && int'(fld) <= NUM_SRC)
          rd_next = BUS_W'(prio_flat[(int'(fld)-1)*PRIO_W +: PRIO_W]);
      end
      RG_PEND: begin
        if (int'(fld) < NWORDS)
          rd_next = pend_words[int'(fld)*32 +: 32];
      end
      RG_EN: begin
        if (int'(e_ctx) < NUM_CTX && int'(e_word) < NWORDS)
          rd_next = en_flat[(int'(e_ctx)*NWORDS + int'(e_word))*32 +: 32];
      end
      RG_CTX: begin
        if (ctx_ok)
          rd_next = c_sel ? BUS_W'(claim_id) : BUS_W'(thr_sel);
      end
      default: rd_next = '0;
    endcase
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      irq_out    <= '0;
    end else begin
      bus_rvalid <= rd_req;
      bus_rdata  <= rd_req ? rd_next : '0;
      irq_out    <= any_vec;
    end
  end
endmodule

// File: rtl/irq_claim_ctrl_chk.sv
module irq_claim_ctrl_chk #(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [11:0]        bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic               bus_rvalid,
  input logic [NUM_CTX-1:0] irq_out,
  input logic [NUM_SRC:1]   pend_q,
  input logic [NUM_SRC:1]   act_q
);
  logic is_read, is_claim_rd, is_comp_wr;
  assign is_read     = bus_sel && !bus_wr;
  assign is_claim_rd = is_read && bus_addr[11:10] == 2'b11 && bus_addr[0];
  assign is_comp_wr  = bus_sel && bus_wr && bus_addr[11:10] == 2'b11 && bus_addr[0];

  // R10
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (irq_out == '0 && !bus_rvalid && pend_q == '0 && act_q == '0));

  // R11
  read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    is_read |=> bus_rvalid);

  // R11
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !is_read |=> !bus_rvalid);

  // R3
  pend_act_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q & act_q) == '0);

  // R2
  empty_claim_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (is_claim_rd && pend_q == '0) |=> bus_rdata == '0);

  // R5
  null_complete_chk: assert property (@(posedge clk) disable iff (rst)
    (is_comp_wr && (bus_wdata == '0 || bus_wdata > NUM_SRC)) |=> $stable(act_q));

  // R8
  quiet_line_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q == '0) |=> irq_out == '0);
endmodule

bind irq_claim_ctrl irq_claim_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_rvalid(bus_rvalid),
  .irq_out   (irq_out),
  .pend_q    (pend_q),
  .act_q     (act_q)
);

// File: tb/test_irq_claim_ctrl.sv
`timescale 1ns/1ps
module test_irq_claim_ctrl;
  localparam int NUM_SRC = 40;
  localparam int NUM_CTX = 2;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_SRC-1:0] src_irq = '0;
  logic               bus_sel = 1'b0;
  logic               bus_wr = 1'b0;
  logic [11:0]        bus_addr = '0;
  logic [31:0]        bus_wdata = '0;
  logic [31:0]        bus_rdata;
  logic               bus_rvalid;
  logic [NUM_CTX-1:0] irq_out;

  always #2 clk = ~clk;

  irq_claim_ctrl #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(3)) i_irq_claim_ctrl (
    .clk(clk), .rst(rst), .src_irq(src_irq),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_out(irq_out)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [11:0] a_prio(int id);          return 12'(id); endfunction
  function automatic logic [11:0] a_pend(int w);           return 12'h400 + 12'(w); endfunction
  function automatic logic [11:0] a_en(int c, int w);      return 12'h800 + 12'(c*32 + w); endfunction
  function automatic logic [11:0] a_thr(int c);            return 12'hC00 + 12'(c*2); endfunction
  function automatic logic [11:0] a_clm(int c);            return 12'hC01 + 12'(c*2); endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the scoreboard whenever read data is presented
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R11 actual=unexpected rvalid expected=no read data");
      end else begin
        check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R10 reset state
    check(32'(irq_out), 32'h0, "R10 irq_out after reset");
    check(32'(bus_rvalid), 32'h0, "R10 rvalid after reset");
    rd(a_clm(0), 32'h0, "R10 claim after reset");
    rd(a_prio(5), 32'h0, "R10 priority after reset");

    // configuration
    wr(a_prio(3), 2);  wr(a_prio(5), 5); wr(a_prio(7), 5);
    wr(a_prio(33), 1); wr(a_prio(9), 0);
    check(32'(bus_rvalid), 32'h0, "R11 no rvalid after write");
    rd(a_prio(5), 32'h5, "R7 priority readback");
    rd(a_prio(0), 32'h0, "R7 id 0 priority");
    wr(a_en(0, 0), 32'h2A9);
    wr(a_en(0, 1), 32'h2);
    wr(a_en(1, 0), 32'h20);
    rd(a_en(0, 0), 32'h2A8, "R6 id 0 enable bit masked");
    rd(a_en(0, 1), 32'h2, "R6 second enable word");

    // raise sources 3,5,7,9,33
    src_irq[2] = 1'b1; src_irq[4] = 1'b1; src_irq[6] = 1'b1;
    src_irq[8] = 1'b1; src_irq[32] = 1'b1;
    idle(3);
    check(32'(irq_out), 32'h3, "R8 both lines raised");
    rd(a_pend(0), 32'h2A8, "R9 pending word 0");
    rd(a_pend(1), 32'h2, "R9 pending word 1");
    wr(a_pend(0), 32'h0);
    rd(a_pend(0), 32'h2A8, "R9 pending write ignored");

    // arbitration and claim
    rd(a_clm(0), 32'd5, "R1 tie goes to lowest id");
    rd(a_clm(1), 32'd0, "R3 active source not offered");
    idle(2);
    check(32'(irq_out[1]), 32'h0, "R8 ctx1 line drops after claim");
    rd(a_clm(0), 32'd7, "R1 second of tie");
    rd(a_clm(0), 32'd3, "R1 next priority");
    rd(a_clm(0), 32'd33, "R6 R7 word 1 source with priority 1");
    rd(a_clm(0), 32'd0, "R2 priority 0 never eligible");
    idle(2);
    check(32'(irq_out[0]), 32'h0, "R8 ctx0 line drops");

    // dropped completions
    wr(a_clm(1), 32'd7);
    wr(a_clm(0), 32'd0);
    wr(a_clm(0), 32'd41);
    idle(3);
    rd(a_pend(0), 32'h200, "R5 completions dropped");

    // cross-context completion
    wr(a_clm(1), 32'd5);
    idle(3);
    check(32'(irq_out[1]), 32'h1, "R4 re-pended after foreign completion");
    rd(a_pend(0), 32'h220, "R4 source 5 pending again");
    rd(a_clm(1), 32'd5, "R4 claim on other context");
    idle(2);
    check(32'(irq_out[1]), 32'h0, "R3 line low while active");

    // threshold
    wr(a_thr(0), 2);
    rd(a_thr(0), 32'h2, "R1 threshold readback");
    wr(a_clm(0), 32'd7);
    wr(a_clm(0), 32'd3);
    idle(3);
    rd(a_clm(0), 32'd7, "R1 above threshold");
    rd(a_clm(0), 32'd0, "R2 priority equal to threshold");
    idle(2);
    check(32'(irq_out[0]), 32'h0, "R8 threshold masks line");

    idle(2);
    check(32'(exp_q.size()), 32'h0, "R11 every read answered");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule